// File: doc/BRIEF.md
# Packet Radio Mode Controller

This block decides the operating mode of a packet radio link: light sleep, transmit or receive. It serves two roles. As the transmitting end it goes into TX on its own whenever the transmit queue holds a packet and the link is enabled, and it drops back to light sleep once the queue has drained. As the receiving end it sits in RX for as long as the link is enabled. The block holds a single enable bit. Software can load this bit directly, a receive strobe sets it, and a sleep strobe clears it. When the enable bit is low, the block is always in light sleep.

Two small counters are packed into one status byte. The low nibble counts retransmit attempts for the packet in flight and restarts at every new packet. The high nibble counts packets that were given up without an acknowledge. It stops at its ceiling and is zeroed by any write to the channel setting. Every output is registered, so each input takes effect at the next clock edge. This block carries only control and status: it has no data stream, so it has no valid/ready handshake.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0, `status` is 8'h00 and `enable` is 0.
- R2: The enable bit loads on each clock edge with this priority. `sleep_cmd` clears it first. Otherwise `rx_cmd` sets it. Otherwise `en_load` copies `en_value`. Otherwise it holds. `enable` shows the bit after the edge.
- R3: With `role_rx` low and the enable bit high, the block stays in light sleep while `txq_empty` is high. From light sleep it moves to TX on the first edge at which `txq_empty` is low.
- R4: In TX with `role_rx` low, the mode holds until `pkt_done` pulses. On that edge it moves to light sleep if `txq_empty` is high, and stays in TX for a new packet if `txq_empty` is low.
- R5: On any edge at which the enable bit becomes or stays low, the mode becomes light sleep. This holds for either role and for any `txq_empty` value.
- R6: With `role_rx` high, the mode becomes RX while the enable bit is high, including on the edge after a `pkt_done` (with or without `ack_ok`). With `role_rx` high the mode never becomes TX.
- R7: `mode` encodes light sleep as 3'd0, TX as 3'd1 and RX as 3'd2. No other value ever appears.
- R8: `status[3:0]` is the retransmit count. It rises by one on each `retry` pulse seen in TX and saturates at 15. It clears to 0 at the start of every new packet, which is entry to TX or staying in TX after `pkt_done`. Clearing wins over counting.
- R9: `status[7:4]` is the lost-packet count. It rises by one when `pkt_done` pulses in TX with `ack_ok` low, and saturates at 15. A `pkt_done` with `ack_ok` high leaves it unchanged.
- R10: A `chan_wr` pulse clears `status[7:4]` to 0 on the next edge, even if a lost packet is counted on the same edge.
- R11: Outside TX, `retry` and `pkt_done` do not raise either count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_rx | input | 1 | 1 = receiving end, 0 = transmitting end |
| en_load | input | 1 | Register write strobe for the enable bit |
| en_value | input | 1 | Value written by `en_load` |
| rx_cmd | input | 1 | Receive strobe; sets the enable bit |
| sleep_cmd | input | 1 | Sleep strobe; clears the enable bit |
| txq_empty | input | 1 | Transmit queue holds no packet |
| pkt_done | input | 1 | Packet exchange finished (pulse) |
| ack_ok | input | 1 | Acknowledge received, qualified by `pkt_done` |
| retry | input | 1 | Retransmit attempt (pulse) |
| chan_wr | input | 1 | Channel setting written (pulse) |
| mode | output | 3 | Current mode: 0 sleep, 1 TX, 2 RX |
| status | output | 8 | {lost count, retransmit count} |
| enable | output | 1 | Current enable bit |

## Verification
On every cycle, the assertions check that the mode encoding is legal and that a low enable bit always means light sleep. They also check that the receiving role never yields TX, that an enabled idle transmitter with a queued packet starts TX, and that a channel write clears the lost count. They also check that retries outside TX cannot raise the retransmit count and that a saturated lost count stays saturated. The bench scenarios are needed for the full sequencing. These cover back-to-back packets with the retransmit count restarting, the priority among the strobes, and saturation of both nibbles. They also cover a clear colliding with an increment, and role changes in mid-packet, all compared cycle by cycle against an independent model.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [2:0] {
    MODE_SLEEP = 3'd0,
    MODE_TX    = 3'd1,
    MODE_RX    = 3'd2
  } mode_e;
endpackage

// File: rtl/rmc_enable.sv
module rmc_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic en_load,
  input  logic en_value,
  input  logic rx_cmd,
  input  logic sleep_cmd,
  output logic en_next,
  output logic en_q
);
  // R2: sleep strobe outranks receive strobe, which outranks a plain write
  always_comb begin
    if (sleep_cmd)    en_next = 1'b0;
    else if (rx_cmd)  en_next = 1'b1;
    else if (en_load) en_next = en_value;
    else              en_next = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_next;
  end
endmodule

// File: rtl/rmc_fsm.sv
module rmc_fsm
  import rmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  role_rx,
  input  logic  en_next,
  input  logic  txq_empty,
  input  logic  pkt_done,
  output mode_e mode_q,
  output logic  new_pkt
);
  mode_e mode_d;

  always_comb begin
    mode_d  = MODE_SLEEP;
    new_pkt = 1'b0;
    if (!en_next) begin
      mode_d = MODE_SLEEP;
    end else if (role_rx) begin
      mode_d = MODE_RX;
    end else if (mode_q == MODE_TX && !pkt_done) begin
      mode_d = MODE_TX;
    end else if (!txq_empty) begin
      mode_d  = MODE_TX;
      new_pkt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SLEEP;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/rmc_sat_counter.sv
module rmc_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CEIL = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != CEIL) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               role_rx,
  input  logic               en_load,
  input  logic               en_value,
  input  logic               rx_cmd,
  input  logic               sleep_cmd,
  input  logic               txq_empty,
  input  logic               pkt_done,
  input  logic               ack_ok,
  input  logic               retry,
  input  logic               chan_wr,
  output logic [2:0]         mode,
  output logic [2*CNT_W-1:0] status,
  output logic               enable
);
  localparam int NCNT = 2;
  localparam int RETX = 0;
  localparam int LOST = 1;

  logic       en_next;
  logic       new_pkt;
  logic       in_tx;
  mode_e      mode_q;
  logic [NCNT-1:0] cnt_clr;
  logic [NCNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [NCNT];

  rmc_enable u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_load   (en_load),
    .en_value  (en_value),
    .rx_cmd    (rx_cmd),
    .sleep_cmd (sleep_cmd),
    .en_next   (en_next),
    .en_q      (enable)
  );

  rmc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .role_rx   (role_rx),
    .en_next   (en_next),
    .txq_empty (txq_empty),
    .pkt_done  (pkt_done),
    .mode_q    (mode_q),
    .new_pkt   (new_pkt)
  );

  assign in_tx = (mode_q == MODE_TX);

  // retransmit count: per packet; lost count: per channel
  assign cnt_clr[RETX] = new_pkt;
  assign cnt_inc[RETX] = in_tx && retry;
  assign cnt_clr[LOST] = chan_wr;
  assign cnt_inc[LOST] = in_tx && pkt_done && !ack_ok;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    rmc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr[i]),
      .inc   (cnt_inc[i]),
      .cnt   (cnt_val[i])
    );
  end

  assign mode   = mode_q;
  assign status = {cnt_val[LOST], cnt_val[RETX]};
endmodule

// File: rtl/rmc_checker.sv
module rmc_checker #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               role_rx,
  input logic               en_load,
  input logic               en_value,
  input logic               sleep_cmd,
  input logic               txq_empty,
  input logic               retry,
  input logic               chan_wr,
  input logic [2:0]         mode,
  input logic [2*CNT_W-1:0] status,
  input logic               enable
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  // R7
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode inside {3'd0, 3'd1, 3'd2});

  // R5
  off_means_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> mode == 3'd0);

  // R6
  rx_role_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    role_rx |=> mode != 3'd1);

  // R3
  tx_autostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_rx && mode == 3'd0 && enable && !txq_empty && !sleep_cmd
     && !(en_load && !en_value)) |=> mode == 3'd1);

  // R10
  chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> status[2*CNT_W-1:CNT_W] == '0);

  // R11
  retry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd1 && retry) |=>
      (status[CNT_W-1:0] == $past(status[CNT_W-1:0]) || status[CNT_W-1:0] == '0));

  // R9
  lost_hold_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2*CNT_W-1:CNT_W] == CEIL && !chan_wr) |=>
      status[2*CNT_W-1:CNT_W] == CEIL);
endmodule

bind radio_mode_ctrl rmc_checker #(.CNT_W(CNT_W)) u_rmc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .role_rx   (role_rx),
  .en_load   (en_load),
  .en_value  (en_value),
  .sleep_cmd (sleep_cmd),
  .txq_empty (txq_empty),
  .retry     (retry),
  .chan_wr   (chan_wr),
  .mode      (mode),
  .status    (status),
  .enable    (enable)
);

// File: tb/radio_mode_ctrl_test.sv
`timescale 1ns/1ps
module radio_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_rx = 1'b0, en_load = 1'b0, en_value = 1'b0, rx_cmd = 1'b0;
  logic sleep_cmd = 1'b0, txq_empty = 1'b1, pkt_done = 1'b0, ack_ok = 1'b0;
  logic retry = 1'b0, chan_wr = 1'b0;
  logic [2:0] mode;
  logic [7:0] status;
  logic enable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit       m_en = 1'b0;
  int       m_mode = 0;
  int       m_retx = 0;
  int       m_lost = 0;

  always #5 clk = ~clk;

  radio_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .role_rx(role_rx), .en_load(en_load),
    .en_value(en_value), .rx_cmd(rx_cmd), .sleep_cmd(sleep_cmd),
    .txq_empty(txq_empty), .pkt_done(pkt_done), .ack_ok(ack_ok),
    .retry(retry), .chan_wr(chan_wr), .mode(mode), .status(status),
    .enable(enable)
  );

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // expected next state, from the requirements
  task automatic model_step();
    bit en_n;
    bit newp;
    int nm;
    en_n = sleep_cmd ? 1'b0 : rx_cmd ? 1'b1 : en_load ? en_value : m_en;
    newp = 1'b0;
    if (!en_n) nm = 0;
    else if (role_rx) nm = 2;
    else if (m_mode == 1 && !pkt_done) nm = 1;
    else if (!txq_empty) begin nm = 1; newp = 1'b1; end
    else nm = 0;
    if (newp) m_retx = 0;
    else if (m_mode == 1 && retry && m_retx < 15) m_retx++;
    if (chan_wr) m_lost = 0;
    else if (m_mode == 1 && pkt_done && !ack_ok && m_lost < 15) m_lost++;
    m_en = en_n;
    m_mode = nm;
  endtask

  task automatic clear_pulses();
    en_load = 0; rx_cmd = 0; sleep_cmd = 0; pkt_done = 0; ack_ok = 0;
    retry = 0; chan_wr = 0;
  endtask

  // one clock with current inputs, then compare everything
  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(mode), m_mode, "mode");
    check(tag, int'(status[3:0]), m_retx, "retx count");
    check(tag, int'(status[7:4]), m_lost, "lost count");
    check(tag, int'(enable), int'(m_en), "enable");
    clear_pulses();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", int'(mode), 0, "mode");
    check("R1", int'(status), 0, "status");
    check("R1", int'(enable), 0, "enable");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 enabled transmitter idles with empty queue
    en_load = 1; en_value = 1; cyc("R3");
    repeat (3) cyc("R3");
    check("R3", int'(mode), 0, "idle mode literal");
    txq_empty = 0; cyc("R3");
    check("R3", int'(mode), 1, "tx start literal");

    // R8 retries count, saturate
    repeat (20) begin retry = 1; cyc("R8"); end
    check("R8", int'(status[3:0]), 15, "retx saturated");

    // R4 back-to-back packet restarts retx count
    pkt_done = 1; ack_ok = 1; cyc("R4");
    check("R4", int'(mode), 1, "stay tx");
    check("R8", int'(status[3:0]), 0, "retx cleared on new packet");
    retry = 1; cyc("R8");
    txq_empty = 1; cyc("R4");
    check("R4", int'(mode), 1, "hold until done");
    pkt_done = 1; ack_ok = 1; cyc("R4");
    check("R4", int'(mode), 0, "sleep after last packet");

    // R11 retries and done outside TX ignored
    retry = 1; cyc("R11");
    pkt_done = 1; cyc("R11");
    check("R11", int'(status), 8'h01, "status unchanged idle");

    // R9 lost packets saturate
    txq_empty = 0;
    cyc("R9");
    repeat (18) begin pkt_done = 1; ack_ok = 0; cyc("R9"); end
    check("R9", int'(status[7:4]), 15, "lost saturated");
    pkt_done = 1; ack_ok = 1; cyc("R9");

    // R10 clear wins over increment
    pkt_done = 1; ack_ok = 0; chan_wr = 1; cyc("R10");
    check("R10", int'(status[7:4]), 0, "lost cleared");

    // R5 disable while queue non-empty
    en_load = 1; en_value = 0; cyc("R5");
    check("R5", int'(mode), 0, "forced sleep");

    // R2 priority
    sleep_cmd = 1; rx_cmd = 1; cyc("R2");
    check("R2", int'(enable), 0, "sleep beats rx");
    rx_cmd = 1; en_load = 1; en_value = 0; cyc("R2");
    check("R2", int'(enable), 1, "rx beats write");

    // R6 receiving role
    role_rx = 1; cyc("R6");
    check("R6", int'(mode), 2, "rx mode literal");
    pkt_done = 1; ack_ok = 0; cyc("R6");
    check("R6", int'(mode), 2, "back to rx");
    sleep_cmd = 1; cyc("R6");
    check("R6", int'(mode), 0, "sleep cmd stops rx");
    rx_cmd = 1; cyc("R6");
    check("R6", int'(mode), 2, "rx strobe enters rx");
    role_rx = 0; txq_empty = 1; cyc("R7");

    // random mix: R2..R11 against the model
    for (int i = 0; i < 4000; i++) begin
      sleep_cmd = ($urandom_range(99) < 2);
      rx_cmd    = ($urandom_range(99) < 3);
      en_load   = ($urandom_range(99) < 5);
      en_value  = ($urandom_range(99) < 75);
      if ($urandom_range(99) < 10) txq_empty = ~txq_empty;
      pkt_done  = ($urandom_range(99) < 10);
      ack_ok    = ($urandom_range(99) < 60);
      retry     = ($urandom_range(99) < 20);
      chan_wr   = ($urandom_range(99) < 2);
      if ($urandom_range(99) < 1) role_rx = ~role_rx;
      cyc("R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule